// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a single-cycle arithmetic unit for 32-bit words that carry packed data. One format select treats the word as four independent unsigned bytes. The other treats it as two signed 16-bit fractions in Q15 form, which cover -1 up to one step below +1. Every lane gets the same operation: add, subtract, shift left or shift right. No carry, borrow or shifted bit ever passes from one lane into a neighbour.

When saturation is on, a lane whose exact result does not fit is clamped to the closest value it can hold. When saturation is off, the lane wraps. A combinational overflow output reports, for the current inputs, whether any lane overflowed. A registered sticky copy gathers overflow across many operations until software-visible logic upstream clears it. Multiplication and accumulators are not part of this block.

Top module: `psimd_sat_alu`

## Requirements
- R1: With `fmt`=0 the word holds four unsigned byte lanes, lane i at bits 8i+7..8i. With `fmt`=1 it holds two signed Q15 lanes, lane i at bits 16i+15..16i. No carry, borrow or shifted-out bit crosses a lane boundary.
- R2: `op` encodes 0 = add, 1 = subtract, 2 = shift left, 3 = shift right. With `sat_en`=0 every lane result wraps modulo 2^(lane width).
- R3: For byte lanes with `sat_en`=1, an add that exceeds 255 gives 0xFF and a subtract that goes below 0 gives 0x00.
- R4: For Q15 lanes with `sat_en`=1, an add or subtract whose exact result is above 32767 gives 0x7FFF, and one below -32768 gives 0x8000.
- R5: Byte lanes shift by `shamt[2:0]` and ignore `shamt[3]`. Q15 lanes shift by `shamt[3:0]`. A right shift is logical for bytes and arithmetic for Q15, and it never overflows.
- R6: A left shift overflows in a byte lane when a 1 is shifted out, and with `sat_en`=1 it gives 0xFF. In a Q15 lane it overflows when the exact product by 2^shamt lies outside -32768..32767, and with `sat_en`=1 it gives 0x7FFF for a non-negative input and 0x8000 for a negative one.
- R7: `ovf` is combinational. It is 1 exactly when at least one lane's exact result is out of range, whether or not `sat_en` is set.
- R8: `ovf_sticky` is 0 after a synchronous active-low reset. At each rising clock edge it becomes 0 if `sticky_clr`=1 (clear wins). Otherwise it becomes 1 if `ovf`=1, and otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Synchronous active-low reset |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand (unused by shifts) |
| op | input | 2 | Operation: 0 add, 1 sub, 2 shift left, 3 shift right |
| fmt | input | 1 | Lane format: 0 four unsigned bytes, 1 two Q15 |
| sat_en | input | 1 | 1 clamps overflowing lanes, 0 wraps |
| shamt | input | 4 | Shift amount |
| sticky_clr | input | 1 | Clears the sticky flag at the next edge |
| result | output | 32 | Packed lane results |
| ovf | output | 1 | Any lane overflowed this cycle |
| ovf_sticky | output | 1 | Overflow accumulated since last clear |

## Verification
The assertions check, on every clock edge, how the sticky flag sets, clears and holds. They also check that a right shift never raises overflow, and that saturated results move the right way: a saturated byte add never drops below its operand, a saturated byte subtract never rises above it, and a saturated sum of two non-negative Q15 values stays non-negative. Only the bench's sweeps can show the exact clamp values, the wrap results, which shift-amount bits each format ignores, and that lanes stay isolated. The bench compares every lane of every swept vector against an integer model.

// File: rtl/psimd_pkg.sv
// Package psimd_pkg
// Shared operation encoding and shift-amount width for the packed SIMD ALU.
// Assumes lane widths of at most 16 bits, so four shift bits suffice.
package psimd_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_SHL = 2'd2,
        OP_SHR = 2'd3
    } simd_op_e;

    localparam int unsigned SHAMT_W = 4;
endpackage

// File: rtl/psimd_lane.sv
// Module psimd_lane
// One lane of the packed ALU: add, subtract, shift left, shift right on a
// W-bit value, either unsigned (SIGNED_Q=0) or two's complement (SIGNED_Q=1).
// It reports whether the exact result left the lane's range and, when
// sat_en is set, replaces the wrapped value with the nearest bound.
// Assumes W is a power of two no wider than 2**SH_W.
module psimd_lane #(
    parameter int unsigned W        = 8,
    parameter bit          SIGNED_Q = 1'b0,
    parameter int unsigned SH_W     = psimd_pkg::SHAMT_W
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [1:0]      op,
    input  logic            sat_en,
    input  logic [SH_W-1:0] shamt,
    output logic [W-1:0]    res,
    output logic            ovf
);
    import psimd_pkg::*;

    localparam int unsigned LSH   = $clog2(W);
    localparam logic [W-1:0] MAXV = SIGNED_Q ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
    localparam logic [W-1:0] MINV = SIGNED_Q ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};

    logic [LSH-1:0] sh;
    logic [W:0]     ax, bx, sum, dif;
    logic [W-1:0]   shl_v, shl_back, shr_v;
    logic           add_o, sub_o;

    assign sh    = shamt[LSH-1:0];
    assign shl_v = a << sh;

    // Variant-specific extension, shift-back and overflow detection.
    generate
        if (SIGNED_Q) begin : g_signed
            logic signed [W-1:0] a_s, shl_s;
            assign a_s      = a;
            assign shl_s    = shl_v;
            assign ax       = {a[W-1], a};
            assign bx       = {b[W-1], b};
            assign shl_back = shl_s >>> sh;
            assign shr_v    = a_s >>> sh;
            assign add_o    = sum[W] ^ sum[W-1];
            assign sub_o    = dif[W] ^ dif[W-1];
        end else begin : g_unsigned
            assign ax       = {1'b0, a};
            assign bx       = {1'b0, b};
            assign shl_back = shl_v >> sh;
            assign shr_v    = a >> sh;
            assign add_o    = sum[W];
            assign sub_o    = dif[W];
        end
    endgenerate

    assign sum = ax + bx;
    assign dif = ax - bx;

    // Select wrapped value, overflow and clamp bound for the current operation.
    always_comb begin
        logic [W-1:0] wrap_v, sat_v;
        logic         o;
        unique case (simd_op_e'(op))
            OP_ADD: begin
                wrap_v = sum[W-1:0];
                o      = add_o;
                sat_v  = (SIGNED_Q && a[W-1]) ? MINV : MAXV;
            end
            OP_SUB: begin
                wrap_v = dif[W-1:0];
                o      = sub_o;
                if (SIGNED_Q) sat_v = a[W-1] ? MINV : MAXV;
                else          sat_v = MINV;
            end
            OP_SHL: begin
                wrap_v = shl_v;
                o      = (shl_back != a);
                sat_v  = (SIGNED_Q && a[W-1]) ? MINV : MAXV;
            end
            default: begin
                wrap_v = shr_v;
                o      = 1'b0;
                sat_v  = shr_v;
            end
        endcase
        ovf = o;
        res = (o && sat_en) ? sat_v : wrap_v;
    end
endmodule

// File: rtl/psimd_sat_alu.sv
// Module psimd_sat_alu
// Top of the packed SIMD saturating ALU. It builds one bank of byte lanes and
// one bank of Q15 lanes over the same word and picks a bank with fmt. It also
// keeps a sticky overflow flag that clears synchronously.
// Assumes DATA_W is a multiple of 16; inputs are held stable around clk.
module psimd_sat_alu #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [DATA_W-1:0]              opa,
    input  logic [DATA_W-1:0]              opb,
    input  logic [1:0]                     op,
    input  logic                           fmt,
    input  logic                           sat_en,
    input  logic [psimd_pkg::SHAMT_W-1:0]  shamt,
    input  logic                           sticky_clr,
    output logic [DATA_W-1:0]              result,
    output logic                           ovf,
    output logic                           ovf_sticky
);
    import psimd_pkg::*;

    localparam int unsigned N8  = DATA_W / 8;
    localparam int unsigned N16 = DATA_W / 16;

    logic [DATA_W-1:0] res8, res16;
    logic [N8-1:0]     ovf8;
    logic [N16-1:0]    ovf16;

    // Unsigned byte lanes.
    generate
        for (genvar g = 0; g < N8; g++) begin : g_b
            psimd_lane #(.W(8), .SIGNED_Q(1'b0), .SH_W(SHAMT_W)) u_lane (
                .a(opa[8*g +: 8]), .b(opb[8*g +: 8]), .op(op), .sat_en(sat_en),
                .shamt(shamt), .res(res8[8*g +: 8]), .ovf(ovf8[g])
            );
        end
        // Signed Q15 lanes.
        for (genvar g = 0; g < N16; g++) begin : g_q
            psimd_lane #(.W(16), .SIGNED_Q(1'b1), .SH_W(SHAMT_W)) u_lane (
                .a(opa[16*g +: 16]), .b(opb[16*g +: 16]), .op(op), .sat_en(sat_en),
                .shamt(shamt), .res(res16[16*g +: 16]), .ovf(ovf16[g])
            );
        end
    endgenerate

    assign result = fmt ? res16 : res8;
    assign ovf    = fmt ? (|ovf16) : (|ovf8);

    // Sticky overflow: clear has priority over a new overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovf_sticky <= 1'b0;
        else if (sticky_clr) ovf_sticky <= 1'b0;
        else if (ovf)        ovf_sticky <= 1'b1;
    end

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !sticky_clr) |=> ovf_sticky);
    // R8
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_clr |=> !ovf_sticky);
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !sticky_clr) |=> $stable(ovf_sticky));
    // R5
    shr_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHR) |-> !ovf);
    // R3
    byte_add_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt && sat_en && op == OP_ADD) |-> (result[7:0] >= opa[7:0]));
    // R3
    byte_sub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt && sat_en && op == OP_SUB) |-> (result[7:0] <= opa[7:0]));
    // R4
    q15_pos_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt && sat_en && op == OP_ADD && !opa[15] && !opb[15]) |-> !result[15]);
endmodule

// File: tb/sim_psimd_sat_alu.sv
`timescale 1ns/1ps
module sim_psimd_sat_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic [1:0]  op = 2'd0;
    logic        fmt = 1'b0, sat_en = 1'b0, sticky_clr = 1'b0;
    logic [3:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf, ovf_sticky;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    psimd_sat_alu u0 (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op), .fmt(fmt),
        .sat_en(sat_en), .shamt(shamt), .sticky_clr(sticky_clr),
        .result(result), .ovf(ovf), .ovf_sticky(ovf_sticky)
    );

    // Integer reference for the whole word.
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  input logic [1:0] o, input logic f, input logic s,
                                  input logic [3:0] sh, output logic [31:0] r,
                                  output logic ov);
        r = '0; ov = 1'b0;
        if (!f) begin
            for (int i = 0; i < 4; i++) begin
                int x, y, v, k; bit lo; int satv;
                x = int'(a[8*i +: 8]); y = int'(b[8*i +: 8]); k = int'(sh[2:0]);
                case (o)
                    2'd0: v = x + y;
                    2'd1: v = x - y;
                    2'd2: v = x * (1 << k);
                    default: v = x >> k;
                endcase
                lo = (v > 255) || (v < 0);
                satv = (v < 0) ? 0 : 255;
                r[8*i +: 8] = (lo && s) ? satv[7:0] : v[7:0];
                ov |= lo;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                int x, y, v, k; bit lo; int satv;
                x = int'($signed(a[16*i +: 16])); y = int'($signed(b[16*i +: 16]));
                k = int'(sh);
                case (o)
                    2'd0: v = x + y;
                    2'd1: v = x - y;
                    2'd2: v = x * (1 << k);
                    default: v = x >>> k;
                endcase
                lo = (v > 32767) || (v < -32768);
                satv = (v < 0) ? -32768 : 32767;
                r[16*i +: 16] = (lo && s) ? satv[15:0] : v[15:0];
                ov |= lo;
            end
        end
    endfunction

    task automatic check(input bit ok, input string req, input logic [32:0] act,
                         input logic [32:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one vector at the falling edge and compare result and ovf.
    task automatic vec(input logic [31:0] a, input logic [31:0] b, input logic [1:0] o,
                       input logic f, input logic s, input logic [3:0] sh, input string req);
        logic [31:0] er; logic eo;
        @(negedge clk);
        opa = a; opb = b; op = o; fmt = f; sat_en = s; shamt = sh;
        #1;
        model(a, b, o, f, s, sh, er, eo);
        check(result === er && ovf === eo, req, {ovf, result}, {eo, er});
    endtask

    function automatic string tag(input logic [1:0] o, input logic f);
        if (o == 2'd3) return "R5";
        if (o == 2'd2) return "R6";
        return f ? "R4" : "R3";
    endfunction

    task automatic finish_report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            finish_report();
        end
    end

    initial begin
        sticky_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check(ovf_sticky === 1'b0, "R8", {32'd0, ovf_sticky}, 33'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1 no carry between byte lanes, wrap without saturation (R2)
        vec(32'h00FF_00FF, 32'h0001_0001, 2'd0, 1'b0, 1'b0, 4'd0, "R1");
        vec(32'h0000_FFFF, 32'h0001_0001, 2'd0, 1'b1, 1'b0, 4'd0, "R1");
        vec(32'h0100_0100, 32'h0001_0001, 2'd1, 1'b0, 1'b0, 4'd0, "R2");
        vec(32'h8001_0180, 32'h0000_0000, 2'd2, 1'b0, 1'b0, 4'd1, "R1");
        // R4 corners, R7 ovf without saturation
        vec(32'h7FFF_8000, 32'h0001_FFFF, 2'd0, 1'b1, 1'b1, 4'd0, "R4");
        vec(32'h8000_7FFF, 32'h0001_FFFF, 2'd1, 1'b1, 1'b1, 4'd0, "R4");
        vec(32'h7FFF_0001, 32'h0001_0001, 2'd0, 1'b1, 1'b0, 4'd0, "R7");
        // R5 byte lanes ignore shamt[3]
        vec(32'h80FF_4001, 32'h0, 2'd3, 1'b0, 1'b0, 4'd9, "R5");
        vec(32'hC000_8001, 32'h0, 2'd3, 1'b1, 1'b0, 4'd15, "R5");
        // R6 Q15 left shift clamp by sign
        vec(32'hC000_4000, 32'h0, 2'd2, 1'b1, 1'b1, 4'd1, "R6");
        vec(32'hBFFF_2000, 32'h0, 2'd2, 1'b1, 1'b1, 4'd2, "R6");

        // Near-exhaustive byte sweep: every lane-0 value against 16 partners
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [7:0] a0, b0; logic [31:0] a, b;
                a0 = 8'(i); b0 = 8'(j * 17 + (j >> 1));
                a = {a0 ^ 8'h5A, a0 + 8'd77, ~a0, a0};
                b = {b0 + 8'd3, ~b0, b0 ^ 8'hC3, b0};
                for (int o = 0; o < 4; o++)
                    for (int s = 0; s < 2; s++)
                        vec(a, b, 2'(o), 1'b0, 1'(s), 4'(j), tag(2'(o), 1'b0));
            end
        end

        // Q15 sweep including the range ends
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                logic [15:0] a0, b0; logic [31:0] a, b;
                a0 = (i == 0) ? 16'h8000 : (i == 1) ? 16'h7FFF : (i == 2) ? 16'h0000
                     : 16'(i * 1031 + i * i * 97);
                b0 = (j == 0) ? 16'h8000 : (j == 1) ? 16'h7FFF : (j == 2) ? 16'hFFFF
                     : 16'(j * 2053 + 5);
                a = {a0 ^ 16'hA5A5, a0};
                b = {~b0, b0};
                for (int o = 0; o < 4; o++)
                    for (int s = 0; s < 2; s++)
                        vec(a, b, 2'(o), 1'b1, 1'(s), 4'(j), tag(2'(o), 1'b1));
            end
        end

        // R8 sticky behaviour
        @(negedge clk); sticky_clr = 1'b1;
        opa = 32'h0; opb = 32'h0; op = 2'd0; fmt = 1'b0; sat_en = 1'b0;
        @(negedge clk); sticky_clr = 1'b0; opa = 32'h0000_00FF; opb = 32'h1;
        @(posedge clk); #1;
        check(ovf_sticky === 1'b1, "R8", {32'd0, ovf_sticky}, 33'd1);
        @(negedge clk); opa = 32'h0; opb = 32'h0;
        @(posedge clk); #1;
        check(ovf_sticky === 1'b1, "R8", {32'd0, ovf_sticky}, 33'd1);
        @(negedge clk); sticky_clr = 1'b1; opa = 32'h0000_00FF; opb = 32'h1;
        @(posedge clk); #1;
        check(ovf_sticky === 1'b0, "R8", {32'd0, ovf_sticky}, 33'd0);
        @(negedge clk); sticky_clr = 1'b0; opa = 32'h0; opb = 32'h0;
        @(posedge clk); #1;
        check(ovf_sticky === 1'b0, "R8", {32'd0, ovf_sticky}, 33'd0);

        done = 1'b1;
        finish_report();
    end
endmodule